// File: doc/BRIEF.md
# Byte-Sliced AES Round Step Unit

This unit performs one byte's share of an AES round on a 32-bit datapath. A byte is picked out of the second operand by a 2-bit lane index and substituted through the forward S-box for encryption or the inverse S-box for decryption. The substituted byte is then either kept alone in the low lane or expanded into the column that MixColumns (or InvMixColumns) produces from one input byte. That word is rotated to the lane the byte came from and XORed into the low word of the first operand. The 32-bit result is sign-extended to the register width and registered.

Software or a sequencer builds a whole round column by issuing four operations in a row. Each one feeds the previous result back as the first operand. The sequencing of whole states and the key expansion sit outside this unit.

Top module: `aes_byte_step`

## Requirements
- R1: The processed byte is `in_rs2[8*in_bsel +: 8]`. Bits of `in_rs2` above bit 31 have no effect on the result.
- R2: With `in_dec` = 0 the byte goes through the forward AES S-box (for example 0x53 gives 0xED and 0x10 gives 0xCA).
- R3: With `in_dec` = 1 the byte goes through the inverse AES S-box (for example 0x63 gives 0x00 and 0x00 gives 0x52).
- R4: With `in_mix` = 0 the column word is the substituted byte s in bits 7:0, with bits 31:8 zero.
- R5: With `in_mix` = 1 and `in_dec` = 0 the column word is {3·s, s, s, 2·s}, listed from bits 31:24 down to bits 7:0. Products are in GF(2^8) modulo x^8+x^4+x^3+x+1 (0x11B).
- R6: With `in_mix` = 1 and `in_dec` = 1 the column word is {0x0B·s, 0x0D·s, 0x09·s, 0x0E·s}, listed from bits 31:24 down to bits 7:0, using the same field.
- R7: The column word is rotated left by 8·`in_bsel` bits and XORed with `in_rs1[31:0]`. Bits of `in_rs1` above bit 31 have no effect on the result.
- R8: `out_result[XLEN-1:32]` are copies of bit 31 of the 32-bit result.
- R9: `out_result` loads only on a clock edge where `in_valid` = 1 and otherwise holds its value. `out_valid` equals the `in_valid` of the previous cycle.
- R10: While `rst_n` = 0, `out_valid` and `out_result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request; loads the output register |
| in_dec | input | 1 | 0 = forward S-box and MixColumns, 1 = inverse S-box and InvMixColumns |
| in_mix | input | 1 | 1 = expand into a column word, 0 = plain substituted byte |
| in_bsel | input | 2 | Byte lane selected from `in_rs2`; also the rotation amount |
| in_rs1 | input | XLEN | Accumulator operand; its low 32 bits are XORed in |
| in_rs2 | input | XLEN | Source operand holding the byte to process |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_result | output | XLEN | Registered, sign-extended result |

## Verification
The lane rotation and the sign extension act in the same cycle. When `in_bsel` is 3, the rotated byte lands in the top lane and its bit 7 decides every upper bit of the result. The bench provokes this directly by substituting 0x00 with mixing enabled, so that bit 31 becomes set. It also provokes it with random operands that cover all four lane indices, with garbage in the upper operand halves. A behavioural model with its own table-generated S-boxes judges each result on every clock, and so does the hold of the result register across idle cycles.

// File: rtl/aes_bs_pkg.sv
package aes_bs_pkg;

   typedef logic [7:0]  lane_t;
   typedef logic [31:0] col_t;

   localparam lane_t GF_REDUCE = 8'h1B;
   localparam lane_t AFF_CONST = 8'h63;
   localparam lane_t AFF_INV_CONST = 8'h05;
   localparam lane_t INV_EXPONENT = 8'd254;

   function automatic lane_t rol8(input lane_t v, input int unsigned n);
      return lane_t'((v << n) | (v >> (8 - n)));
   endfunction

   function automatic lane_t gf_dbl(input lane_t v);
      return v[7] ? lane_t'((v << 1) ^ GF_REDUCE) : lane_t'(v << 1);
   endfunction

   function automatic lane_t gf_mul(input lane_t a, input lane_t b);
      lane_t acc;
      lane_t term;
      acc  = '0;
      term = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) acc = acc ^ term;
         term = gf_dbl(term);
      end
      return acc;
   endfunction

   // Multiplicative inverse as a^254 (maps 0 to 0).
   function automatic lane_t gf_inv(input lane_t a);
      lane_t r;
      r = 8'h01;
      for (int i = 7; i >= 0; i--) begin
         r = gf_mul(r, r);
         if (INV_EXPONENT[i]) r = gf_mul(r, a);
      end
      return r;
   endfunction

   function automatic lane_t aff_fwd(input lane_t v);
      return v ^ rol8(v, 1) ^ rol8(v, 2) ^ rol8(v, 3) ^ rol8(v, 4) ^ AFF_CONST;
   endfunction

   function automatic lane_t aff_rev(input lane_t v);
      return rol8(v, 1) ^ rol8(v, 3) ^ rol8(v, 6) ^ AFF_INV_CONST;
   endfunction

   // Column coefficient for output lane j (lane 0 = bits 7:0).
   function automatic lane_t mix_coef(input int unsigned j, input logic dec);
      lane_t c;
      case (j)
         0:       c = dec ? 8'h0E : 8'h02;
         1:       c = dec ? 8'h09 : 8'h01;
         2:       c = dec ? 8'h0D : 8'h01;
         default: c = dec ? 8'h0B : 8'h03;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/aes_bs_sbox.sv
module aes_bs_sbox
   import aes_bs_pkg::*;
#(
   parameter int SHARE_INV = 1
) (
   input  logic  dec,
   input  lane_t din,
   output lane_t dout
);

   generate
      if (SHARE_INV != 0 && SHARE_INV != 1) begin : g_bad_share
         $error("aes_bs_sbox: SHARE_INV must be 0 or 1");
      end

      if (SHARE_INV == 1) begin : g_shared
         // One inverter; the affine maps are steered around it.
         lane_t pre;
         lane_t inv;
         always_comb begin
            pre  = dec ? aff_rev(din) : din;
            inv  = gf_inv(pre);
            dout = dec ? inv : aff_fwd(inv);
         end
      end else begin : g_split
         // Separate inverters per direction: shorter path, more area.
         lane_t fwd;
         lane_t rev;
         always_comb begin
            fwd  = aff_fwd(gf_inv(din));
            rev  = gf_inv(aff_rev(din));
            dout = dec ? rev : fwd;
         end
      end
   endgenerate

endmodule

// File: rtl/aes_bs_mix.sv
module aes_bs_mix
   import aes_bs_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic  dec,
   input  logic  mix,
   input  lane_t s,
   output col_t  word
);

   localparam int LANE_W = 8;

   generate
      if (LANES * LANE_W != $bits(col_t)) begin : g_bad_lanes
         $error("aes_bs_mix: LANES must fill one column word");
      end
   endgenerate

   genvar j;
   generate
      for (j = 0; j < LANES; j++) begin : g_lane
         lane_t prod;
         always_comb begin
            prod = gf_mul(s, mix_coef(j, dec));
            if (mix)
               word[j*LANE_W +: LANE_W] = prod;
            else if (j == 0)
               word[j*LANE_W +: LANE_W] = s;
            else
               word[j*LANE_W +: LANE_W] = '0;
         end
      end
   endgenerate

endmodule

// File: rtl/aes_byte_step.sv
module aes_byte_step
   import aes_bs_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter int SHARE_INV = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic            in_dec,
   input  logic            in_mix,
   input  logic [1:0]      in_bsel,
   input  logic [XLEN-1:0] in_rs1,
   input  logic [XLEN-1:0] in_rs2,
   output logic            out_valid,
   output logic [XLEN-1:0] out_result
);

   localparam int COL_W  = $bits(col_t);
   localparam int LANE_W = $bits(lane_t);
   localparam int LANES  = COL_W / LANE_W;
   localparam int EXT_W  = XLEN - COL_W;

   generate
      if (XLEN < COL_W) begin : g_bad_xlen
         $error("aes_byte_step: XLEN must be at least 32");
      end
   endgenerate

   lane_t sel_byte;
   lane_t sub_byte;
   col_t  mix_word;
   col_t  rot_word;
   col_t  acc_word;
   logic [XLEN-1:0] ext_word;

   // R1: lane pick from the low word of the source operand
   assign sel_byte = in_rs2[LANE_W*in_bsel +: LANE_W];

   aes_bs_sbox #(.SHARE_INV(SHARE_INV)) sbox_i (
      .dec  (in_dec),
      .din  (sel_byte),
      .dout (sub_byte)
   );

   aes_bs_mix #(.LANES(LANES)) mix_i (
      .dec  (in_dec),
      .mix  (in_mix),
      .s    (sub_byte),
      .word (mix_word)
   );

   // R7: rotate left by whole lanes
   always_comb begin
      logic [1:0] src;
      for (int j = 0; j < LANES; j++) begin
         src = 2'(j) - in_bsel;
         rot_word[j*LANE_W +: LANE_W] = mix_word[LANE_W*src +: LANE_W];
      end
   end

   assign acc_word = rot_word ^ in_rs1[COL_W-1:0];

   generate
      if (EXT_W > 0) begin : g_ext
         logic unused_hi;
         assign unused_hi = ^{in_rs1[XLEN-1:COL_W], in_rs2[XLEN-1:COL_W]};
         assign ext_word  = {{EXT_W{acc_word[COL_W-1]}}, acc_word};
      end else begin : g_noext
         assign ext_word = acc_word;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_result <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_result <= ext_word;
      end
   end

   // ---------------- assertions ----------------
   assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_valid_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_result_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_result));

   // R4: plain mode keeps only the substituted byte in lane 0
   assert_plain_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !in_mix |-> (mix_word[COL_W-1:LANE_W] == '0 && mix_word[LANE_W-1:0] == sub_byte));

   // R5: forward column has two copies of s and 3s ^ 2s == s
   assert_fwd_column_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_mix && !in_dec) |-> (mix_word[23:16] == sub_byte && mix_word[15:8] == sub_byte
                               && (mix_word[31:24] ^ mix_word[7:0]) == sub_byte));

   // R6: coefficients 0B^0D^09^0E reduce to 1, so the lanes XOR to s
   assert_inv_column_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_mix && in_dec) |-> ((mix_word[31:24] ^ mix_word[23:16] ^ mix_word[15:8]
                               ^ mix_word[7:0]) == sub_byte));

   generate
      if (EXT_W > 0) begin : g_ext_chk
         assert_sign_ext_R8: assert property (@(posedge clk) disable iff (!rst_n)
            out_result[XLEN-1:COL_W] == {EXT_W{out_result[COL_W-1]}});
      end
   endgenerate

endmodule

// File: tb/aes_byte_step_tb_top.sv
module aes_byte_step_tb_top;

   localparam int XLEN = 64;
   localparam int WATCHDOG_CYCLES = 50000;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic            in_dec = 1'b0;
   logic            in_mix = 1'b0;
   logic [1:0]      in_bsel = '0;
   logic [XLEN-1:0] in_rs1 = '0;
   logic [XLEN-1:0] in_rs2 = '0;
   logic            out_valid;
   logic [XLEN-1:0] out_result;

   int n_checks = 0;
   int n_fails  = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   aes_byte_step #(.XLEN(XLEN)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dec(in_dec),
      .in_mix(in_mix), .in_bsel(in_bsel), .in_rs1(in_rs1), .in_rs2(in_rs2),
      .out_valid(out_valid), .out_result(out_result)
   );

   // ---- reference tables built by walking the field generator ----
   logic [7:0] fwd_tab [256];
   logic [7:0] inv_tab [256];

   function automatic logic [7:0] r8(input logic [7:0] v, input int n);
      return 8'((v << n) | (v >> (8 - n)));
   endfunction

   function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
      logic [15:0] wide = '0;
      for (int i = 0; i < 8; i++) if (b[i]) wide = wide ^ (16'(a) << i);
      for (int i = 15; i >= 8; i--) if (wide[i]) wide = wide ^ (16'h011B << (i - 8));
      return wide[7:0];
   endfunction

   initial begin
      logic [7:0] p = 8'h01;
      logic [7:0] q = 8'h01;
      do begin
         p = p ^ 8'(p << 1) ^ (p[7] ? 8'h1B : 8'h00);
         q = q ^ 8'(q << 1);
         q = q ^ 8'(q << 2);
         q = q ^ 8'(q << 4);
         if (q[7]) q = q ^ 8'h09;
         fwd_tab[p] = q ^ r8(q, 1) ^ r8(q, 2) ^ r8(q, 3) ^ r8(q, 4) ^ 8'h63;
      end while (p != 8'h01);
      fwd_tab[0] = 8'h63;
      for (int i = 0; i < 256; i++) inv_tab[fwd_tab[i]] = 8'(i);
   end

   function automatic logic [XLEN-1:0] model(input logic dec, input logic mix,
         input logic [1:0] bsel, input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
      logic [7:0]  x = 8'(b >> (8 * bsel));
      logic [7:0]  s = dec ? inv_tab[x] : fwd_tab[x];
      logic [31:0] w;
      logic [31:0] r;
      if (!mix)      w = {24'h0, s};
      else if (!dec) w = {fmul(s, 8'h03), s, s, fmul(s, 8'h02)};
      else           w = {fmul(s, 8'h0B), fmul(s, 8'h0D), fmul(s, 8'h09), fmul(s, 8'h0E)};
      r = (w << (8 * bsel)) | (w >> (32 - 8 * bsel));
      r = r ^ a[31:0];
      return {{(XLEN-32){r[31]}}, r};
   endfunction

   // ---- cycle model ----
   logic            exp_valid = 1'b0;
   logic [XLEN-1:0] exp_result = '0;
   string           exp_tag = "R10";

   always @(posedge clk) begin
      if (!rst_n) begin
         exp_valid  = 1'b0;
         exp_result = '0;
         exp_tag    = "R10";
      end else begin
         exp_valid = in_valid;
         if (in_valid) begin
            exp_result = model(in_dec, in_mix, in_bsel, in_rs1, in_rs2);
            if (!in_mix)     exp_tag = in_dec ? "R3/R4" : "R2/R4";
            else if (in_dec) exp_tag = "R6";
            else             exp_tag = "R5";
         end else begin
            exp_tag = "R9";
         end
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         n_checks++;
         if (out_valid !== exp_valid) begin
            n_fails++;
            $display("FAIL R9 out_valid actual=%0b expected=%0b", out_valid, exp_valid);
         end
         n_checks++;
         if (out_result !== exp_result) begin
            n_fails++;
            $display("FAIL %s out_result actual=%h expected=%h", exp_tag, out_result, exp_result);
         end
      end
   end

   task automatic drive(input logic v, input logic dec, input logic mix,
         input logic [1:0] bsel, input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
      @(negedge clk);
      in_valid = v; in_dec = dec; in_mix = mix; in_bsel = bsel; in_rs1 = a; in_rs2 = b;
   endtask

   task automatic directed(input logic v, input logic dec, input logic mix,
         input logic [1:0] bsel, input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
         input logic [XLEN-1:0] expv, input string tag);
      drive(v, dec, mix, bsel, a, b);
      @(posedge clk);
      #1;
      n_checks++;
      if (out_result !== expv) begin
         n_fails++;
         $display("FAIL %s directed actual=%h expected=%h", tag, out_result, expv);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R2: forward S-box 0x53 -> 0xED
      directed(1, 0, 0, 2'd0, 64'h0, 64'h53, 64'h0000_0000_0000_00ED, "R2");
      // R3: inverse S-box 0x63 -> 0x00, XORed with 0x11
      directed(1, 1, 0, 2'd0, 64'h11, 64'h63, 64'h0000_0000_0000_0011, "R3");
      // R1 and R7: lane 2, garbage above bit 31 of the source operand
      directed(1, 0, 0, 2'd2, 64'h0, 64'hFFFF_FFFF_0053_0000, 64'h0000_0000_00ED_0000, "R1/R7");
      // R4: plain word, lane 1, 0x10 -> 0xCA
      directed(1, 0, 0, 2'd1, 64'hFF, 64'h1000, 64'h0000_0000_0000_CAFF, "R4");
      // R5 and R8: forward column of 0x63 gives A56363C6, bit 31 set
      directed(1, 0, 1, 2'd0, 64'h0, 64'h0, 64'hFFFF_FFFF_A563_63C6, "R5/R8");
      // R6: inverse column of 0x52
      directed(1, 1, 1, 2'd0, 64'h0, 64'h0, 64'h0000_0000_50A7_F451, "R6");
      // R7 and R8: lane 3 rotation, upper accumulator bits ignored
      directed(1, 0, 0, 2'd3, 64'hABCD_0000_0000_0000, 64'h0, 64'h0000_0000_6300_0000, "R7/R8");
      // R9: idle cycle with changed operands leaves the result unchanged
      directed(0, 1, 1, 2'd2, 64'h1234, 64'h5678, 64'h0000_0000_6300_0000, "R9");
      // R8: lane 3 with mixing so bit 31 is set by the rotation
      directed(1, 0, 1, 2'd3, 64'h0, 64'h0, 64'hFFFF_FFFF_C6A5_6363, "R7/R8");
      // random traffic against the cycle model
      for (int k = 0; k < 3000; k++) begin
         drive(1'($urandom % 4 != 0), 1'($urandom), 1'($urandom), 2'($urandom),
               {$urandom, $urandom}, {$urandom, $urandom});
      end
      // R10: reset in the middle of traffic
      drive(1, 0, 1, 2'd1, 64'h1, 64'h2);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) drive(1, 1, 0, 2'd0, 64'h0, 64'h0);
      drive(0, 0, 0, 2'd0, 64'h0, 64'h0);
      @(negedge clk);
      #1;
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (WATCHDOG_CYCLES) @(posedge clk);
      if (!done) begin
         done = 1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

endmodule